// File: doc/BRIEF.md
# Serial Split-Word Arithmetic Unit

This block is a bit-serial two's-complement accumulator unit. It handles one 24-bit word per word time, least significant bit first, one bit per clock. Each word time, a serial operand stream is combined with the accumulator under an operation code. The operations are clear-and-add, add, subtract, and one-place arithmetic shifts. An external bit-position counter tells the unit which bit is present on the operand line. A start pulse marks bit 0 and selects the operation for the whole pass. A done pulse follows the last bit.

A split family of operations treats the word as two independent 11-bit halves. The lower half sits in bits 10..0 and the upper half in bits 22..12. The carry chain is cut at the half boundary, so one serial pass performs two separate additions or subtractions. The shift path is cut at the same boundary. A split shift may act on both halves, or on only the upper half or only the lower half. In split mode, bit 11 and bit 23 are written as zero.

The accumulator is visible in parallel after every pass and bit by bit while a pass runs. A minus flag follows the accumulator's sign for conditional branching.

Top module: `serial_split_alu`

## Requirements
- R1: A synchronous active-low reset clears the accumulator and the minus flag and drops done. This applies mid-pass too, and the interrupted pass then produces no done pulse.
- R2: Operation code 0 (clear-and-add) loads the 24-bit operand into the accumulator.
- R3: Operation code 1 (add) leaves accumulator plus operand, modulo 2^24.
- R4: Operation code 2 (subtract) leaves accumulator minus operand, modulo 2^24, formed as a two's-complement addition.
- R5: Operation code 3 (split add) adds the operand halves to the accumulator halves, each modulo 2^11. The halves are bits 10..0 and bits 22..12. No carry passes between the halves, and bits 11 and 23 of the result are zero.
- R6: Operation code 4 (split subtract) subtracts each operand half from the matching accumulator half, modulo 2^11. It uses the same field positions, no borrow crosses the boundary, and bits 11 and 23 are zero.
- R7: Operation code 5 shifts the whole accumulator right one place and copies bit 23 into bit 23. Operation code 6 shifts it left one place, fills bit 0 with zero and discards the old bit 23.
- R8: Operation codes 7 (right) and 8 (left) shift both 11-bit halves by one place independently. A right shift copies the half's own top bit. A left shift fills the half's bottom bit with zero. Bits 11 and 23 become zero.
- R9: Operation codes 9 (right) and 10 (left) shift only the upper half. Codes 11 (right) and 12 (left) shift only the lower half. The other half keeps its value and bits 11 and 23 become zero.
- R10: Operation codes 13 to 15 leave the accumulator unchanged.
- R11: After each pass, the minus flag equals bit 23 of the new accumulator.
- R12: A pass begins when start is high while the bit position is 0. Start at any other position is ignored. Done is high for exactly the one cycle after bit 23, and the parallel output then shows the result. During a pass the serial output carries the result bit for the current position.
- R13: A new pass may start in the same cycle in which done reports the previous one. Back-to-back passes each produce correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pass start, valid with bit position 0 |
| bit_idx_i | input | 5 | Position of the bit on the operand line |
| op_i | input | 4 | Operation code, sampled with start |
| opd_bit_i | input | 1 | Serial operand bit, least significant first |
| acc_o | output | 24 | Accumulator in parallel, valid when done or idle |
| ser_o | output | 1 | Result bit of the current position during a pass |
| minus_o | output | 1 | Sign of the accumulator after the last pass |
| done_o | output | 1 | One-cycle pulse after bit 23 |

## Verification
The end of one pass and the start of the next can fall in the same cycle. In that cycle done reports the finished word while bit 0 of the next word is already being consumed and its operation code latched. The stimulus table is played back with no idle cycle between passes, so every vector after the first sees a start in its predecessor's done cycle. The bench judges that cycle by requiring done high and the full previous result on the parallel output and minus flag, before the new pass has changed any register.

// File: rtl/ssau_pkg.sv
// Package for the serial split-word arithmetic unit.
// Holds the operation encoding and small decode helpers shared by all modules.
package ssau_pkg;

    typedef enum logic [3:0] {
        OP_CLA  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SADD = 4'd3,
        OP_SSUB = 4'd4,
        OP_SHR  = 4'd5,
        OP_SHL  = 4'd6,
        OP_SSHR = 4'd7,
        OP_SSHL = 4'd8,
        OP_UHR  = 4'd9,
        OP_UHL  = 4'd10,
        OP_LHR  = 4'd11,
        OP_LHL  = 4'd12,
        OP_RSV0 = 4'd13,
        OP_RSV1 = 4'd14,
        OP_RSV2 = 4'd15
    } op_e;

    // True for every operation that works on two half words.
    function automatic logic op_is_split(input op_e o);
        case (o)
            OP_SADD, OP_SSUB, OP_SSHR, OP_SSHL,
            OP_UHR, OP_UHL, OP_LHR, OP_LHL: op_is_split = 1'b1;
            default:                        op_is_split = 1'b0;
        endcase
    endfunction

    // True for the two subtracting operations.
    function automatic logic op_is_sub(input op_e o);
        op_is_sub = (o == OP_SUB) || (o == OP_SSUB);
    endfunction

endpackage

// File: rtl/ssau_lane_map.sv
// Lane map: classifies the current bit position as bottom, top or gap of its
// field, and as lower or upper half.
// Assumes HI_BASE >= HALF_W and HI_BASE + HALF_W <= WORD_W.
// In full-word mode the field spans the whole word and there is no gap.
module ssau_lane_map #(
    parameter int WORD_W = 24,
    parameter int HALF_W = 11,
    parameter int HI_BASE = 12,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             split,
    output logic             bottom,
    output logic             top,
    output logic             gap,
    output logic             upper
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0] LO_TOP   = IDX_W'(HALF_W - 1);
    localparam logic [IDX_W-1:0] HI_BOT   = IDX_W'(HI_BASE);
    localparam logic [IDX_W-1:0] HI_TOP   = IDX_W'(HI_BASE + HALF_W - 1);
    localparam logic [IDX_W-1:0] LO_END   = IDX_W'(HALF_W);

    // Decode field edges for the active mode.
    always_comb begin
        upper = (bit_idx >= HI_BOT);
        if (split) begin
            bottom = (bit_idx == '0) || (bit_idx == HI_BOT);
            top    = (bit_idx == LO_TOP) || (bit_idx == HI_TOP);
            gap    = ((bit_idx >= LO_END) && (bit_idx < HI_BOT)) || (bit_idx > HI_TOP);
        end else begin
            bottom = (bit_idx == '0);
            top    = (bit_idx == LAST_IDX);
            gap    = 1'b0;
        end
    end

endmodule

// File: rtl/ssau_bit_slice.sv
// One-bit serial datapath step: full adder with injected carry at field bottoms,
// one-place shift selection, and gap clearing.
// Assumes a_next holds the old bit one position up and a_prev the old bit one
// position down, each valid when it is used.
module ssau_bit_slice
    import ssau_pkg::*;
(
    input  op_e  op,
    input  logic a_cur,
    input  logic a_next,
    input  logic a_prev,
    input  logic opd,
    input  logic carry_q,
    input  logic bottom,
    input  logic top,
    input  logic gap,
    input  logic upper,
    output logic res,
    output logic carry_out
);

    logic sub, b_eff, cin, sum, rsh, lsh;

    // Form the adder and shift candidates for this bit.
    always_comb begin
        sub       = op_is_sub(op);
        b_eff     = opd ^ sub;
        cin       = bottom ? sub : carry_q;
        sum       = a_cur ^ b_eff ^ cin;
        carry_out = (a_cur & b_eff) | (a_cur & cin) | (b_eff & cin);
        rsh       = top ? a_cur : a_next;
        lsh       = bottom ? 1'b0 : a_prev;
    end

    // Select the result bit for the operation and clear gap positions.
    always_comb begin
        case (op)
            OP_CLA:                         res = opd;
            OP_ADD, OP_SUB, OP_SADD, OP_SSUB: res = sum;
            OP_SHR, OP_SSHR:                res = rsh;
            OP_SHL, OP_SSHL:                res = lsh;
            OP_UHR:                         res = upper ? rsh : a_cur;
            OP_UHL:                         res = upper ? lsh : a_cur;
            OP_LHR:                         res = upper ? a_cur : rsh;
            OP_LHL:                         res = upper ? a_cur : lsh;
            default:                        res = a_cur;
        endcase
        if (gap) res = 1'b0;
    end

endmodule

// File: rtl/ssau_ctrl.sv
// Pass sequencer: accepts start at bit 0, holds the operation for the pass,
// tracks activity and raises done for one cycle after the last bit.
// Assumes the bit position advances by one each cycle during a pass.
module ssau_ctrl
    import ssau_pkg::*;
#(
    parameter int WORD_W = 24,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] bit_idx,
    input  op_e              op_in,
    output logic             busy,
    output logic             last_step,
    output op_e              eff_op,
    output op_e              op_q,
    output logic             done_q
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    logic start_ok, active_q;

    // Decode acceptance and the operation in force this cycle.
    always_comb begin
        start_ok  = start_i && (bit_idx == '0);
        busy      = start_ok || active_q;
        last_step = busy && (bit_idx == LAST_IDX);
        eff_op    = start_ok ? op_in : op_q;
    end

    // Track pass activity, latch the operation and emit done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            op_q     <= OP_CLA;
            done_q   <= 1'b0;
        end else begin
            if (start_ok) op_q <= op_in;
            if (last_step) active_q <= 1'b0;
            else if (start_ok) active_q <= 1'b1;
            done_q <= last_step;
        end
    end

    // R12: done follows the last bit step.
    p_done_after_last_r12: assert property (@(posedge clk) disable iff (!rst_n)
        last_step |=> done_q);

    // R12: done lasts a single cycle.
    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/serial_split_alu.sv
// Serial split-word arithmetic unit, top level.
// The accumulator is a rotating shift register: each busy cycle the oldest bit
// leaves at position 0 and the result bit enters at the top, so after a full
// pass the word is back in place. Assumes start comes with bit position 0.
module serial_split_alu
    import ssau_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int HALF_W = 11,
    parameter int HI_BASE = 12,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    input  logic [3:0]        op_i,
    input  logic              opd_bit_i,
    output logic [WORD_W-1:0] acc_o,
    output logic              ser_o,
    output logic              minus_o,
    output logic              done_o
);

    logic [WORD_W-1:0] acc_sr;
    logic carry_q, prev_q, minus_q, seen_q;
    logic busy, last_step, done_q;
    op_e  eff_op, op_q;
    logic bottom, top, gap, upper;
    logic res, carry_nx;

    ssau_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .bit_idx   (bit_idx_i),
        .op_in     (op_e'(op_i)),
        .busy      (busy),
        .last_step (last_step),
        .eff_op    (eff_op),
        .op_q      (op_q),
        .done_q    (done_q)
    );

    ssau_lane_map #(.WORD_W(WORD_W), .HALF_W(HALF_W), .HI_BASE(HI_BASE)) u_map (
        .bit_idx (bit_idx_i),
        .split   (op_is_split(eff_op)),
        .bottom  (bottom),
        .top     (top),
        .gap     (gap),
        .upper   (upper)
    );

    ssau_bit_slice u_slice (
        .op        (eff_op),
        .a_cur     (acc_sr[0]),
        .a_next    (acc_sr[1]),
        .a_prev    (prev_q),
        .opd       (opd_bit_i),
        .carry_q   (carry_q),
        .bottom    (bottom),
        .top       (top),
        .gap       (gap),
        .upper     (upper),
        .res       (res),
        .carry_out (carry_nx)
    );

    // Rotate the accumulator and keep carry, previous bit and sign per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_sr  <= '0;
            carry_q <= 1'b0;
            prev_q  <= 1'b0;
            minus_q <= 1'b0;
        end else if (busy) begin
            acc_sr  <= {res, acc_sr[WORD_W-1:1]};
            carry_q <= carry_nx;
            prev_q  <= acc_sr[0];
            if (last_step) minus_q <= res;
        end
    end

    // Marks cycles whose previous sample was taken after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // Drive the outputs.
    always_comb begin
        acc_o   = acc_sr;
        ser_o   = busy ? res : 1'b0;
        minus_o = minus_q;
        done_o  = done_q;
    end

    // R11: the sign flag only moves when a pass completes.
    p_minus_moves_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$stable(minus_o)) |-> done_o);

    // R5: split results leave both gap bits clear.
    p_split_gaps_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_is_split(op_q)) |-> (!acc_o[HI_BASE-1] && !acc_o[WORD_W-1]));

    // R11: after a pass the flag matches the accumulator's top bit.
    p_minus_matches_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (minus_o == acc_o[WORD_W-1]));

endmodule

// File: tb/serial_split_alu_bench.sv
`timescale 1ns/1ps
module serial_split_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  bit_idx_i = '0;
    logic [3:0]  op_i = '0;
    logic        opd_bit_i = 1'b0;
    logic [23:0] acc_o;
    logic        ser_o, minus_o, done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    serial_split_alu u_serial_split_alu (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_idx_i(bit_idx_i),
        .op_i(op_i), .opd_bit_i(opd_bit_i), .acc_o(acc_o), .ser_o(ser_o),
        .minus_o(minus_o), .done_o(done_o)
    );

    // {op, operand, expected accumulator}, played back to back from reset.
    localparam int NV = 28;
    localparam logic [51:0] VEC [NV] = '{
        {4'd0,  24'h000005, 24'h000005},
        {4'd1,  24'h000003, 24'h000008},
        {4'd2,  24'h000010, 24'hFFFFF8},
        {4'd5,  24'h000000, 24'hFFFFFC},
        {4'd6,  24'h000000, 24'hFFFFF8},
        {4'd0,  24'h7FFFFF, 24'h7FFFFF},
        {4'd1,  24'h000001, 24'h800000},
        {4'd5,  24'h000000, 24'hC00000},
        {4'd0,  24'h800001, 24'h800001},
        {4'd6,  24'h000000, 24'h000002},
        {4'd0,  24'h0017FF, 24'h0017FF},
        {4'd3,  24'h7FF001, 24'h000000},
        {4'd0,  24'hFFFFFF, 24'hFFFFFF},
        {4'd3,  24'h000000, 24'h7FF7FF},
        {4'd4,  24'h002001, 24'h7FD7FE},
        {4'd7,  24'h000000, 24'h7FE7FF},
        {4'd8,  24'h000000, 24'h7FC7FE},
        {4'd9,  24'h000000, 24'h7FE7FE},
        {4'd12, 24'h000000, 24'h7FE7FC},
        {4'd10, 24'h000000, 24'h7FC7FC},
        {4'd11, 24'h000000, 24'h7FC7FE},
        {4'd0,  24'h000400, 24'h000400},
        {4'd11, 24'h000000, 24'h000600},
        {4'd15, 24'hFFFFFF, 24'h000600},
        {4'd13, 24'h123456, 24'h000600},
        {4'd0,  24'hFFFFFF, 24'hFFFFFF},
        {4'd10, 24'h000000, 24'h7FE7FF},
        {4'd14, 24'h000001, 24'h7FE7FF}
    };

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0:        tag_of = "R2";
            4'd1:        tag_of = "R3";
            4'd2:        tag_of = "R4";
            4'd3:        tag_of = "R5";
            4'd4:        tag_of = "R6";
            4'd5, 4'd6:  tag_of = "R7";
            4'd7, 4'd8:  tag_of = "R8";
            4'd9, 4'd10, 4'd11, 4'd12: tag_of = "R9";
            default:     tag_of = "R10";
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_result(input int k, input string done_tag);
        logic [23:0] exp;
        exp = VEC[k][23:0];
        check(acc_o == exp, tag_of(VEC[k][51:48]), acc_o, exp);
        check(minus_o == exp[23], "R11", {23'd0, minus_o}, {23'd0, exp[23]});
        check(done_o == 1'b1, done_tag, {23'd0, done_o}, 24'd1);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [23:0] v;
        int errs;
        int dones;
        // R1: reset state.
        repeat (3) @(negedge clk);
        check(acc_o == 24'd0, "R1", acc_o, 24'd0);
        check({minus_o, done_o} == 2'b00, "R1", {22'd0, minus_o, done_o}, 24'd0);
        rst_n = 1'b1;

        // Table walked back to back; each check lands in the next start cycle (R13).
        for (int k = 0; k < NV; k++) begin
            for (int i = 0; i < 24; i++) begin
                @(negedge clk);
                if (i == 0 && k > 0) check_result(k - 1, "R13");
                start_i   = (i == 0);
                bit_idx_i = 5'(i);
                op_i      = VEC[k][51:48];
                opd_bit_i = VEC[k][24 + i];
            end
        end
        @(negedge clk);
        check_result(NV - 1, "R12");
        start_i = 1'b0; bit_idx_i = '0;
        @(negedge clk);
        check(done_o == 1'b0, "R12", {23'd0, done_o}, 24'd0);

        // R12: serial output carries each result bit of a clear-and-add pass.
        v = 24'hA5C3E1;
        errs = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            start_i = (i == 0); bit_idx_i = 5'(i); op_i = 4'd0; opd_bit_i = v[i];
            #1;
            if (ser_o !== v[i]) errs++;
        end
        check(errs == 0, "R12", 24'(errs), 24'd0);
        @(negedge clk);
        start_i = 1'b0; bit_idx_i = '0;
        check(acc_o == v && done_o, "R12", acc_o, v);

        // R12: start away from bit 0 is ignored.
        dones = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (done_o) dones++;
            start_i = (i == 0); bit_idx_i = 5'((i + 5) % 24); op_i = 4'd0; opd_bit_i = 1'b1;
        end
        @(negedge clk);
        if (done_o) dones++;
        start_i = 1'b0;
        check(dones == 0, "R12", 24'(dones), 24'd0);
        check(acc_o == v, "R12", acc_o, v);

        // R1: reset in mid-pass clears state and suppresses done.
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            start_i = (i == 0); bit_idx_i = 5'(i); op_i = 4'd1; opd_bit_i = 1'b1;
        end
        @(negedge clk);
        start_i = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(acc_o == 24'd0, "R1", acc_o, 24'd0);
        dones = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            bit_idx_i = 5'((i + 12) % 24);
            if (done_o) dones++;
        end
        check(dones == 0 && minus_o == 1'b0, "R1", 24'(dones), 24'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule